// File: doc/BRIEF.md
# Sound DSP Host Command Processor

This block is the host-facing command engine of a simple sound-card signal processor. The host drives byte-wide reads and writes to four offsets. One offset resets the engine. One takes command and parameter bytes. One returns reply bytes. One reports whether reply data is waiting. The engine gathers a command byte and the fixed number of parameter bytes that command needs, then runs it. Commands can set the playback rate, start or stop 8-bit playback of a given number of samples, answer an identification probe, or raise an interrupt on demand.

Playback is a down-counter on the sample count. While samples remain, the engine holds a DMA request. Each acknowledged element takes one from the count, and when the count runs out the request drops and the interrupt line rises. Rate commands turn a one-byte time constant into a frequency. A serial divider computes the frequency, which is then rounded to the nearest standard audio rate. While the divider is working, a finished command waits in a single holding slot.

Top module: `snd_dsp_cmd`

## Requirements
- R1: After `rst_n` low, the state is as follows. The reply stack holds the single byte 0xAA, so a status read returns 0x80. The interrupt, `dma_req` and `busy` are low, and `rate_hz` is 22050. A write to offset 0x6 (`host_addr`=6) restores the same stack and command state, but it leaves the rate and any playback running.
- R2: With no command open, a byte written to offset 0xC (`host_addr`=12) is a command. The next bytes are its parameters. Command 0x40 takes 1 parameter, 0xE0 takes 1, 0x14 takes 2, and 0xB0 through 0xCF take 3. Every other command takes 0 and runs as soon as it is written. Unknown commands run as no-ops.
- R3: Command 0x40 with time constant t sets `rate_hz` as follows. First q = floor(1000000/(256-t)). The result is 48000 if q>46050, 44100 if q>38050, 32000 if q>28000, 24000 if q>23025, 22050 if q>19025, 16000 if q>14000, 12000 if q>11512, 11025 if q>9512, and 8000 otherwise. The first test that holds wins.
- R4: Command 0x14 with parameters lo, hi starts playback of lo+256*hi+1 samples. `dma_req` stays high until exactly that many cycles have had `dma_req` and `dma_ack` both high.
- R5: Commands 0xB0 through 0xCF start playback the same way. Their first parameter is a mode byte, which is ignored. The count comes from parameters two (lo) and three (hi).
- R6: When the last sample is acknowledged, `dma_req` falls and `irq` rises on the same clock edge.
- R7: Command 0xD0 stops playback at once, without raising `irq`.
- R8: Command 0xF2 raises `irq`. Any host read of offset 0xE clears `irq`.
- R9: Command 0xE0 pushes the bitwise complement of its parameter. A read of offset 0xA (`host_addr`=10) pops and returns the newest byte. On an empty stack it returns the bottom slot again. The stack holds 10 bytes, and further pushes are dropped.
- R10: A read of offset 0xC returns 0x00. A read of offset 0xE returns 0x80 when the stack is not empty, and 0x00 otherwise.
- R11: A finished command waits in one holding slot while a rate division runs, and `busy` is high while the slot or the divider is occupied. A command that finishes while the slot is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Low nibble of the host port offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the cycle of `host_rd` |
| dma_req | output | 1 | Playback wants a sample element |
| dma_ack | input | 1 | Element delivered this cycle |
| irq | output | 1 | Interrupt request |
| rate_hz | output | 16 | Current standard sample rate |
| busy | output | 1 | Command slot or rate divider occupied |

## Verification
Several properties are checked on every cycle. The reply stack never exceeds its depth. `rate_hz` is always one of the nine standard rates. A request never appears with a zero remaining count. `irq` only rises after a command execution or an active transfer. A held command stays held while the divider runs. Other behaviour only shows up in the bench's scenarios. These are the exact rounding for each of the 256 time constants, the exact number of acknowledged elements before the interrupt, LIFO order and dropping on a full stack, and the parameter-length table as seen through which byte is taken as the next command.

// File: rtl/snd_dsp_pkg.sv
// Shared constants and helpers for the sound DSP command processor.
// Assumes byte-wide host traffic and 16-bit rate values.
package snd_dsp_pkg;
    localparam logic [7:0] OP_RATE  = 8'h40;
    localparam logic [7:0] OP_PLAY8 = 8'h14;
    localparam logic [7:0] OP_HALT  = 8'hD0;
    localparam logic [7:0] OP_IDENT = 8'hE0;
    localparam logic [7:0] OP_IRQ   = 8'hF2;

    localparam logic [3:0] OFS_RESET = 4'h6;
    localparam logic [3:0] OFS_RDATA = 4'hA;
    localparam logic [3:0] OFS_WDATA = 4'hC;
    localparam logic [3:0] OFS_STAT  = 4'hE;

    // Number of parameter bytes following a command byte.
    function automatic logic [1:0] param_len(input logic [7:0] op);
        if (op == OP_RATE || op == OP_IDENT) return 2'd1;
        if (op == OP_PLAY8)                  return 2'd2;
        if (op >= 8'hB0 && op <= 8'hCF)      return 2'd3;
        return 2'd0;
    endfunction

    // True for the generic playback command range.
    function automatic logic is_generic(input logic [7:0] op);
        return (op[7:4] == 4'hB) || (op[7:4] == 4'hC);
    endfunction

    // Round a raw quotient to the nearest standard rate.
    function automatic logic [15:0] snap_rate(input logic [19:0] q);
        if (q > 20'd46050) return 16'd48000;
        if (q > 20'd38050) return 16'd44100;
        if (q > 20'd28000) return 16'd32000;
        if (q > 20'd23025) return 16'd24000;
        if (q > 20'd19025) return 16'd22050;
        if (q > 20'd14000) return 16'd16000;
        if (q > 20'd11512) return 16'd12000;
        if (q > 20'd9512)  return 16'd11025;
        return 16'd8000;
    endfunction

    // True when r is one of the nine standard rates.
    function automatic logic is_std_rate(input logic [15:0] r);
        return r == 16'd8000  || r == 16'd11025 || r == 16'd12000 ||
               r == 16'd16000 || r == 16'd22050 || r == 16'd24000 ||
               r == 16'd32000 || r == 16'd44100 || r == 16'd48000;
    endfunction
endpackage

// File: rtl/dsp_outbuf.sv
// Reply byte stack (LIFO). Pop returns the newest byte; on empty the
// bottom slot is returned again. Pushes beyond DEPTH are dropped.
// Assumes a pop and a push in one cycle act pop-first.
module dsp_outbuf #(
    parameter int DEPTH = 10,
    parameter int DW = 8,
    parameter logic [7:0] SEED = 8'hAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] top,
    output logic          nonempty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt, after_pop;

    // Level after an optional pop, base for a push.
    always_comb after_pop = (pop && cnt != '0) ? cnt - 1'b1 : cnt;

    assign top      = (cnt != '0) ? mem[AW'(cnt - 1'b1)] : mem[0];
    assign nonempty = (cnt != '0);

    // Stack storage and level update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            mem[0] <= DW'(SEED);
            cnt    <= CW'(1);
        end else if (push && after_pop < CW'(DEPTH)) begin
            mem[AW'(after_pop)] <= push_data;
            cnt                 <= after_pop + 1'b1;
        end else begin
            cnt <= after_pop;
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R1
    clr_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (nonempty && top == DW'(SEED)));
endmodule

// File: rtl/dsp_rate_div.sv
// Serial restoring divider: DIVIDEND / (256 - tc), one quotient bit per
// cycle, then one cycle to round to a standard rate. Assumes start is
// only pulsed while busy is low.
module dsp_rate_div #(
    parameter int QW = 20,
    parameter int DVW = 9,
    parameter int DIVIDEND = 1000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  tc,
    output logic        busy,
    output logic [15:0] rate
);
    import snd_dsp_pkg::*;
    localparam int CW = $clog2(QW + 1);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_SNAP} div_state_e;
    div_state_e     st;
    logic [CW-1:0]  iter;
    logic [DVW-1:0] rem, dvs;
    logic [QW-1:0]  quo;
    logic [DVW:0]   trial;
    logic           fits;

    // One restoring step: shift in next dividend bit and compare.
    always_comb begin
        trial = {rem, quo[QW-1]};
        fits  = trial >= {1'b0, dvs};
    end

    assign busy = (st != S_IDLE);

    // Division sequencer and rate register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            iter <= '0;
            rem  <= '0;
            dvs  <= '0;
            quo  <= '0;
            rate <= 16'd22050;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    st   <= S_RUN;
                    iter <= CW'(QW);
                    rem  <= '0;
                    quo  <= QW'(DIVIDEND);
                    dvs  <= DVW'(256) - DVW'(tc);
                end
                S_RUN: begin
                    rem  <= fits ? DVW'(trial - {1'b0, dvs}) : DVW'(trial);
                    quo  <= {quo[QW-2:0], fits};
                    iter <= iter - 1'b1;
                    if (iter == CW'(1)) st <= S_SNAP;
                end
                default: begin
                    rate <= snap_rate(quo);
                    st   <= S_IDLE;
                end
            endcase
        end
    end

    // R3
    std_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_std_rate(rate));
    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: rtl/dsp_playback.sv
// Playback sample counter: holds a request while samples remain, takes one
// per acknowledge, pulses done on the last one. Start overrides a run.
module dsp_playback #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic             halt,
    input  logic             ack,
    output logic             req,
    output logic             done
);
    logic [CNT_W-1:0] remain;
    logic             playing;

    assign req  = playing;
    assign done = playing && ack && remain == CNT_W'(1) && !start && !halt;

    // Remaining-count register and run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            playing <= 1'b0;
            remain  <= '0;
        end else if (start) begin
            playing <= 1'b1;
            remain  <= start_cnt;
        end else if (halt) begin
            playing <= 1'b0;
            remain  <= '0;
        end else if (playing && ack) begin
            remain  <= remain - 1'b1;
            if (remain == CNT_W'(1)) playing <= 1'b0;
        end
    end

    // R4
    no_empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> remain != '0);
    // R7
    halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !start) |=> !req);
endmodule

// File: rtl/snd_dsp_cmd.sv
// Host command processor of a simple sound DSP. Collects a command byte
// and its parameters, parks the finished command in a one-entry slot and
// runs it once the rate divider is idle. Assumes one host access per cycle.
module snd_dsp_cmd #(
    parameter int OUT_DEPTH = 10,
    parameter int CNT_W = 17
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [3:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        dma_req,
    input  logic        dma_ack,
    output logic        irq,
    output logic [15:0] rate_hz,
    output logic        busy
);
    import snd_dsp_pkg::*;

    logic       port_rst, data_wr, pop, stat_rd;
    logic       have_cmd, cmd_done, slot_free;
    logic [1:0] need, got;
    logic [7:0] cur_cmd, par0, par1, done_cmd;
    logic       ex_vld, ex_fire;
    logic [7:0] ex_cmd, ex_p0, ex_p1, ex_last;
    logic       div_busy, div_start, pb_start, pb_halt, pb_done, push;
    logic [CNT_W-1:0] pb_cnt;
    logic [7:0] ob_top;
    logic       ob_nonempty;

    assign port_rst = host_wr && host_addr == OFS_RESET;
    assign data_wr  = host_wr && host_addr == OFS_WDATA;
    assign pop      = host_rd && host_addr == OFS_RDATA;
    assign stat_rd  = host_rd && host_addr == OFS_STAT;
    assign ex_fire  = ex_vld && !div_busy;
    assign slot_free = !ex_vld || ex_fire;
    assign busy     = ex_vld || div_busy;

    // Detect the byte that completes a command.
    always_comb begin
        cmd_done = 1'b0;
        done_cmd = cur_cmd;
        if (data_wr) begin
            if (!have_cmd) begin
                cmd_done = (param_len(host_wdata) == 2'd0);
                done_cmd = host_wdata;
            end else begin
                cmd_done = ({1'b0, got} + 3'd1) == {1'b0, need};
            end
        end
    end

    // Byte collector and one-entry execution slot.
    always_ff @(posedge clk) begin
        if (!rst_n || port_rst) begin
            have_cmd <= 1'b0; need <= '0; got <= '0;
            cur_cmd <= '0; par0 <= '0; par1 <= '0;
            ex_vld <= 1'b0; ex_cmd <= '0; ex_p0 <= '0; ex_p1 <= '0; ex_last <= '0;
        end else begin
            if (ex_fire) ex_vld <= 1'b0;
            if (data_wr) begin
                if (!have_cmd) begin
                    if (!cmd_done) begin
                        have_cmd <= 1'b1;
                        cur_cmd  <= host_wdata;
                        need     <= param_len(host_wdata);
                        got      <= '0;
                    end
                end else if (cmd_done) begin
                    have_cmd <= 1'b0;
                end else begin
                    if (got == 2'd0) par0 <= host_wdata;
                    else             par1 <= host_wdata;
                    got <= got + 1'b1;
                end
            end
            if (cmd_done && slot_free) begin
                ex_vld  <= 1'b1;
                ex_cmd  <= done_cmd;
                ex_p0   <= have_cmd ? par0 : 8'h00;
                ex_p1   <= have_cmd ? par1 : 8'h00;
                ex_last <= host_wdata;
            end
        end
    end

    // Decode the parked command when it fires.
    always_comb begin
        div_start = ex_fire && ex_cmd == OP_RATE;
        pb_halt   = ex_fire && ex_cmd == OP_HALT;
        push      = ex_fire && ex_cmd == OP_IDENT;
        pb_start  = ex_fire && (ex_cmd == OP_PLAY8 || is_generic(ex_cmd));
        pb_cnt    = (ex_cmd == OP_PLAY8) ? CNT_W'({ex_last, ex_p0}) + 1'b1
                                         : CNT_W'({ex_last, ex_p1}) + 1'b1;
    end

    // Interrupt flag: set by command or end of playback, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  irq <= 1'b0;
        else if ((ex_fire && ex_cmd == OP_IRQ) || pb_done) irq <= 1'b1;
        else if (stat_rd)                            irq <= 1'b0;
    end

    // Host read multiplexer.
    always_comb begin
        host_rdata = 8'h00;
        if (host_rd) begin
            case (host_addr)
                OFS_RDATA: host_rdata = ob_top;
                OFS_STAT:  host_rdata = {ob_nonempty, 7'b0};
                default:   host_rdata = 8'h00;
            endcase
        end
    end

    dsp_outbuf #(.DEPTH(OUT_DEPTH), .DW(8), .SEED(8'hAA)) outbuf_i (
        .clk(clk), .rst_n(rst_n), .clr(port_rst), .push(push),
        .push_data(~ex_last), .pop(pop), .top(ob_top), .nonempty(ob_nonempty)
    );

    dsp_rate_div #(.QW(20), .DVW(9), .DIVIDEND(1000000)) div_i (
        .clk(clk), .rst_n(rst_n), .start(div_start), .tc(ex_last),
        .busy(div_busy), .rate(rate_hz)
    );

    dsp_playback #(.CNT_W(CNT_W)) pb_i (
        .clk(clk), .rst_n(rst_n), .start(pb_start), .start_cnt(pb_cnt),
        .halt(pb_halt), .ack(dma_ack), .req(dma_req), .done(pb_done)
    );

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ex_vld) || $past(dma_req)));
    // R10
    wstat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_WDATA) |-> host_rdata == 8'h00);
    // R11
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_vld && div_busy && !port_rst) |=> ex_vld);
    // R6
    end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pb_done |=> (irq && !dma_req));
endmodule

// File: tb/snd_dsp_cmd_tb_top.sv
module snd_dsp_cmd_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic host_wr = 0, host_rd = 0, dma_ack = 0;
    logic [3:0] host_addr = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic dma_req, irq, busy;
    logic [15:0] rate_hz;
    int errors = 0, checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    snd_dsp_cmd dut_i (.clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dma_req(dma_req), .dma_ack(dma_ack), .irq(irq), .rate_hz(rate_hz), .busy(busy));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        host_rd = 1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 100) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    function automatic int exp_rate(input int t);
        int q = 1000000 / (256 - t);
        if (q > (44100 + 48000) / 2) return 48000;
        if (q > (32000 + 44100) / 2) return 44100;
        if (q > (24000 + 32000) / 2) return 32000;
        if (q > (22050 + 24000) / 2) return 24000;
        if (q > (16000 + 22050) / 2) return 22050;
        if (q > (12000 + 16000) / 2) return 16000;
        if (q > (11025 + 12000) / 2) return 12000;
        if (q > (8000 + 11025) / 2)  return 11025;
        return 8000;
    endfunction

    // Acknowledge every request; return number of acknowledged elements.
    task automatic run_play(output int seen);
        int guard = 0;
        seen = 0;
        dma_ack = 1;
        while (guard < 70000) begin
            if (dma_req) seen++;
            else if (seen > 0) break;
            @(negedge clk);
            guard++;
        end
        dma_ack = 0;
    endtask

    task automatic play_case(input logic [7:0] op, input logic [7:0] lo,
                             input logic [7:0] hi, input string req);
        int n; logic [7:0] s;
        wr(4'hC, op);
        if (op != 8'h14) wr(4'hC, 8'h10);
        wr(4'hC, lo); wr(4'hC, hi);
        run_play(n);
        check(n == lo + 256 * hi + 1, req, n, lo + 256 * hi + 1);
        check(irq == 1'b1 && dma_req == 1'b0, "R6", irq, 1);
        rd(4'hE, s);
        check(irq == 1'b0, "R8", irq, 0);
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(rate_hz == 16'd22050, "R1", rate_hz, 22050);
        check(!irq && !dma_req && !busy, "R1", {irq, dma_req, busy}, 0);
        rd(4'hE, d); check(d == 8'h80, "R1", d, 8'h80);
        // R10 write status always zero
        rd(4'hC, d); check(d == 8'h00, "R10", d, 0);
        // R9 pop seed, then empty repeat of bottom slot
        rd(4'hA, d); check(d == 8'hAA, "R9", d, 8'hAA);
        rd(4'hA, d); check(d == 8'hAA, "R9", d, 8'hAA);
        rd(4'hE, d); check(d == 8'h00, "R10", d, 0);
        // R9 fill beyond depth
        for (int i = 0; i < 11; i++) begin wr(4'hC, 8'hE0); wr(4'hC, 8'(i * 16 + 3)); end
        @(negedge clk);
        rd(4'hE, d); check(d == 8'h80, "R10", d, 8'h80);
        for (int i = 9; i >= 0; i--) begin
            rd(4'hA, d); check(d == ~8'(i * 16 + 3), "R9", d, ~8'(i * 16 + 3));
        end
        rd(4'hE, d); check(d == 8'h00, "R9", d, 0);
        rd(4'hA, d); check(d == 8'hFC, "R9", d, 8'hFC);
        // R2 zero-parameter unknown command, next byte is a command
        wr(4'hC, 8'h55); wr(4'hC, 8'hE0); wr(4'hC, 8'h00); @(negedge clk);
        rd(4'hA, d); check(d == 8'hFF, "R2", d, 8'hFF);
        // R3 sweep all time constants
        for (int t = 0; t < 256; t++) begin
            wr(4'hC, 8'h40); wr(4'hC, 8'(t));
            check(busy == 1'b1, "R11", busy, 1);
            wait_idle();
            check(rate_hz == 16'(exp_rate(t)), "R3", rate_hz, exp_rate(t));
        end
        // R11 held command and dropped command during division
        rd(4'hE, d); check(d == 8'h00, "R11", d, 0);
        wr(4'hC, 8'h40); wr(4'hC, 8'h83);
        wr(4'hC, 8'hE0); wr(4'hC, 8'h5A);
        wr(4'hC, 8'hE0); wr(4'hC, 8'h11);
        rd(4'hE, d); check(d == 8'h00 && busy, "R11", d, 0);
        wait_idle();
        check(rate_hz == 16'd8000, "R3", rate_hz, 8000);
        rd(4'hA, d); check(d == 8'hA5, "R11", d, 8'hA5);
        rd(4'hE, d); check(d == 8'h00, "R11", d, 0);
        // R4 / R5 / R6 playback lengths
        play_case(8'h14, 8'h00, 8'h00, "R4");
        play_case(8'h14, 8'h04, 8'h00, "R4");
        play_case(8'h14, 8'hFF, 8'h00, "R4");
        play_case(8'h14, 8'h00, 8'h01, "R4");
        play_case(8'h14, 8'hFF, 8'hFF, "R4");
        play_case(8'hB0, 8'h02, 8'h00, "R5");
        play_case(8'hC4, 8'h00, 8'h01, "R5");
        // R7 halt mid-playback
        wr(4'hC, 8'h14); wr(4'hC, 8'd100); wr(4'hC, 8'h00);
        dma_ack = 1; repeat (5) @(negedge clk); dma_ack = 0;
        check(dma_req == 1'b1, "R4", dma_req, 1);
        wr(4'hC, 8'hD0); repeat (2) @(negedge clk);
        check(dma_req == 1'b0 && irq == 1'b0, "R7", {dma_req, irq}, 0);
        // R8 forced interrupt
        wr(4'hC, 8'hF2); @(negedge clk);
        check(irq == 1'b1, "R8", irq, 1);
        rd(4'hE, d); check(irq == 1'b0, "R8", irq, 0);
        // R1 reset port mid-command clears collector and reseeds stack
        wr(4'hC, 8'h14); wr(4'hC, 8'h05);
        wr(4'h6, 8'h00);
        wr(4'hC, 8'hE0); wr(4'hC, 8'h0F); @(negedge clk);
        rd(4'hA, d); check(d == 8'hF0, "R1", d, 8'hF0);
        rd(4'hA, d); check(d == 8'hAA, "R1", d, 8'hAA);
        check(rate_hz == 16'd8000, "R1", rate_hz, 8000);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule